// File: doc/BRIEF.md
# Dual-Bus Sensor Reading Queue with Thermal Event Detection

This block accepts 15-bit sensor packets that have already been deserialized from two independent sensor buses. Each packet holds a type bit, a 3-bit sensor number and an 11-bit reading. A packet that arrives on an enabled bus goes into that bus's own 8-entry queue. When the packet is a temperature reading, the block compares it at that moment against two signed thresholds. One is a hardware-protect limit. The other is an alert limit whose direction can be selected.

Firmware reaches the block through a small byte-wide register port. Through it, firmware enables the buses, chooses which queue the data registers show, sets the occupancy level that raises the "reading received" event and programs both thresholds. It also reads the occupancy and overflow status of each queue and drains readings. A reading is drained in two reads. The first read returns the fraction and the descriptor fields. The second read returns the whole-number part and removes the entry. Three pending event flags drive an interrupt request and a prioritised interrupt code. Each event also produces a one-cycle wake pulse.

Top module: `sensor_fifo_thresh`

## Requirements
- R1: A packet presented with `in_vld[b]` high on an enabled bus b is appended to that bus's queue in the clock edge that samples it. Entries leave in arrival order. The packet layout is bit 14 = type (0 temperature, 1 voltage), bits 13:11 = sensor number, bits 10:0 = reading.
- R2: While a bus's enable bit is clear (CTRL address 0: bit 0 enables bus 0, bit 1 enables bus 1), packets on that bus are ignored and its count does not change.
- R3: A queue holds at most 8 entries. A packet that arrives while its queue is full is discarded and sets that bus's sticky overflow bit. The status registers are at address 6 for bus 0 and address 7 for bus 1, and read as {overflow, 3'b000, count[3:0]}. Reading a status register clears its overflow bit.
- R4: The fraction register (address 8) reads {violation, type, number[2:0], reading[2:0]} of the head entry of the selected queue. Reading it does not change the queue.
- R5: Reading the whole register (address 9) returns reading[10:3] of the head entry and removes that entry. On an empty queue, both data registers read 0 and nothing changes.
- R6: CTRL bit 2 selects which queue the data registers show and which queue is popped (0 for bus 0, 1 for bus 1).
- R7: The level register (address 1) holds in bits 2:0 the bus 0 level minus one and in bits 5:3 the bus 1 level minus one. The "reading received" event (event bit 0) is set when a push brings the occupancy to exactly that level.
- R8: When CTRL bit 3 is set, a pushed temperature reading that is greater than or equal (signed 11-bit) to the hardware-protect threshold sets event bit 2. That threshold is {address 2, address 3 bits 2:0}, and after reset it equals (90-64)<<3, so address 2 reads 8'h1A and address 3 reads 0.
- R9: When CTRL bit 4 is set, a pushed temperature reading sets event bit 1 if it is ≥ the alert threshold {address 4, address 5 bits 2:0}. When CTRL bit 5 is set, the test becomes < the threshold instead. The violation flag stored with the entry is set when either threshold event fires for it.
- R10: Voltage packets (type 1) never set event bit 1 or event bit 2, and their violation flag is 0.
- R11: The event register (address 10) reads the pending bits {hp, alert, received} in bits 2:0. Writing a 1 to a bit clears it. `irq` is high while any bit is pending. `irq_id` is 1 for received, 2 for alert and 3 for hardware-protect, the lowest pending code wins, and it is 0 when nothing is pending.
- R12: `wake[2:0]` pulses for exactly one cycle, in the cycle after the edge at which the corresponding event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 2 | Packet valid, one bit per bus |
| in_pkt0 | input | 15 | Packet from bus 0 |
| in_pkt1 | input | 15 | Packet from bus 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| irq | output | 1 | Any event pending |
| irq_id | output | 2 | Highest-priority pending event code |
| wake | output | 3 | One-cycle event pulses {hp, alert, received} |

## Verification
Two cases are the hardest to reach from the ports: a full queue that receives a ninth packet, and a reading that lies exactly on a threshold under each polarity. The stimulus fills bus 0 with eight distinct readings and pushes a ninth. It then drains all eight entries and checks that the ninth packet never appears. The threshold cases come from a vector table of readings at, just below and far from both limits, with negative values included. The table is walked under both polarities. The hardware-protect limit is left at its reset value, so the table also checks the default threshold.

// File: rtl/sensor_fifo_thresh.sv
module sensor_fifo_thresh #(
  parameter int DEPTH    = 8,
  parameter int PKT_W    = 15,
  parameter int RD_W     = 11,
  parameter int FR_W     = 3,
  parameter int NUM_W    = 3,
  parameter int TEMP_OFS = 64,
  parameter int HP_DEF_C = 90
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       in_vld,
  input  logic [PKT_W-1:0] in_pkt0,
  input  logic [PKT_W-1:0] in_pkt1,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [3:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq,
  output logic [1:0]       irq_id,
  output logic [2:0]       wake
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int EW   = PKT_W + 1;
  localparam int WH_W = RD_W - FR_W;
  localparam logic [RD_W-1:0] HP_RAW = RD_W'((HP_DEF_C - TEMP_OFS) << FR_W);

  localparam logic [3:0] A_CTRL = 4'd0, A_LVL = 4'd1, A_HPW = 4'd2, A_HPF = 4'd3,
                         A_ALW  = 4'd4, A_ALF = 4'd5, A_ST0 = 4'd6, A_ST1 = 4'd7,
                         A_FRAC = 4'd8, A_WHOLE = 4'd9, A_EVT = 4'd10;

  logic [7:0]      ctrl, lvl;
  logic [WH_W-1:0] hpw, alw;
  logic [FR_W-1:0] hpf, alf;
  logic [2:0]      pend;

  logic [PKT_W-1:0] pk [2];
  logic [EW-1:0]    mem [2][DEPTH];
  logic [AW-1:0]    wp [2];
  logic [AW-1:0]    rp [2];
  logic [CW-1:0]    cnt [2];
  logic [CW-1:0]    cnt_nx [2];
  logic [CW-1:0]    thr [2];
  logic signed [RD_W-1:0] rdg [2];
  logic [1:0] ovf, push, pop, full_hit, sens, alh, hph;

  logic signed [RD_W-1:0] hp_thr, al_thr;
  logic             rd_whole, sel, hd_ok;
  logic [EW-1:0]    hd;
  logic [2:0]       ev, clr;

  assign pk[0]    = in_pkt0;
  assign pk[1]    = in_pkt1;
  assign hp_thr   = {hpw, hpf};
  assign al_thr   = {alw, alf};
  assign sel      = ctrl[2];
  assign rd_whole = reg_rd && (reg_addr == A_WHOLE);

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      rdg[b]      = pk[b][RD_W-1:0];
      full_hit[b] = in_vld[b] && ctrl[b] && (cnt[b] == CW'(DEPTH));
      push[b]     = in_vld[b] && ctrl[b] && (cnt[b] != CW'(DEPTH));
      pop[b]      = rd_whole && (sel == b[0]) && (cnt[b] != '0);
      thr[b]      = CW'(lvl[b*AW +: AW]) + 1'b1;
      cnt_nx[b]   = cnt[b] + CW'(push[b]) - CW'(pop[b]);
      sens[b]     = push[b] && (cnt_nx[b] == thr[b]);
      hph[b]      = push[b] && !pk[b][PKT_W-1] && ctrl[3] && (rdg[b] >= hp_thr);
      alh[b]      = push[b] && !pk[b][PKT_W-1] && ctrl[4] && ((rdg[b] >= al_thr) ^ ctrl[5]);
    end
  end

  assign ev  = {|hph, |alh, |sens};
  assign clr = (reg_wr && reg_addr == A_EVT) ? reg_wdata[2:0] : 3'b000;

  assign hd    = mem[sel][rp[sel]];
  assign hd_ok = cnt[sel] != '0;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl;
      A_LVL:   reg_rdata = lvl;
      A_HPW:   reg_rdata = 8'(hpw);
      A_HPF:   reg_rdata = 8'(hpf);
      A_ALW:   reg_rdata = 8'(alw);
      A_ALF:   reg_rdata = 8'(alf);
      A_ST0:   reg_rdata = {ovf[0], {(7-CW){1'b0}}, cnt[0]};
      A_ST1:   reg_rdata = {ovf[1], {(7-CW){1'b0}}, cnt[1]};
      A_FRAC:  reg_rdata = hd_ok ? {hd[EW-1], hd[PKT_W-1], hd[PKT_W-2 -: NUM_W], hd[FR_W-1:0]} : 8'h00;
      A_WHOLE: reg_rdata = hd_ok ? 8'(hd[RD_W-1:FR_W]) : 8'h00;
      A_EVT:   reg_rdata = {5'b0, pend};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq    = |pend;
  assign irq_id = pend[0] ? 2'd1 : pend[1] ? 2'd2 : pend[2] ? 2'd3 : 2'd0;

  always_ff @(posedge clk) begin
    for (int b = 0; b < 2; b++)
      if (push[b]) mem[b][wp[b]] <= {alh[b] | hph[b], pk[b]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      lvl  <= '0;
      hpw  <= HP_RAW[RD_W-1:FR_W];
      hpf  <= HP_RAW[FR_W-1:0];
      alw  <= '0;
      alf  <= '0;
      pend <= '0;
      wake <= '0;
      ovf  <= '0;
      for (int b = 0; b < 2; b++) begin
        wp[b]  <= '0;
        rp[b]  <= '0;
        cnt[b] <= '0;
      end
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: ctrl <= reg_wdata;
          A_LVL:  lvl  <= reg_wdata;
          A_HPW:  hpw  <= reg_wdata[WH_W-1:0];
          A_HPF:  hpf  <= reg_wdata[FR_W-1:0];
          A_ALW:  alw  <= reg_wdata[WH_W-1:0];
          A_ALF:  alf  <= reg_wdata[FR_W-1:0];
          default: ;
        endcase
      end
      pend <= (pend & ~clr) | ev;
      wake <= ev;
      for (int b = 0; b < 2; b++) begin
        if (push[b]) wp[b] <= wp[b] + 1'b1;
        if (pop[b])  rp[b] <= rp[b] + 1'b1;
        cnt[b] <= cnt_nx[b];
        if (full_hit[b])
          ovf[b] <= 1'b1;
        else if (reg_rd && reg_addr == (A_ST0 + 4'(b)))
          ovf[b] <= 1'b0;
      end
    end
  end

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[0] <= CW'(DEPTH) && cnt[1] <= CW'(DEPTH));

  a_r3_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld[0] && ctrl[0] && cnt[0] == CW'(DEPTH)) |=> ovf[0]);

  a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !pop[0]) |=> cnt[0] == $past(cnt[0]));

  a_r5_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_whole && !sel && cnt[0] != '0 && !push[0]) |=> cnt[0] == CW'($past(cnt[0]) - 1'b1));

  a_r12_wake_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wake != 3'b000) |-> ((pend & wake) == wake));
endmodule

// File: tb/sensor_fifo_thresh_bench.sv
module sensor_fifo_thresh_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  in_vld = '0;
  logic [14:0] in_pkt0 = '0, in_pkt1 = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq;
  logic [1:0]  irq_id;
  logic [2:0]  wake;

  int tests = 0;
  int fails = 0;
  logic [7:0] d;

  always #5 clk = ~clk;

  sensor_fifo_thresh u_sensor_fifo_thresh (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_pkt0(in_pkt0), .in_pkt1(in_pkt1),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .irq_id(irq_id), .wake(wake));

  // {pol, expect_alert, expect_hp, raw}; alert thr = 132, hp thr = 208 (reset value)
  localparam logic [13:0] VEC [10] = '{
    {1'b0, 1'b1, 1'b1, 11'd208},
    {1'b0, 1'b1, 1'b0, 11'd207},
    {1'b0, 1'b1, 1'b0, 11'd132},
    {1'b0, 1'b0, 1'b0, 11'd131},
    {1'b1, 1'b1, 1'b0, 11'd131},
    {1'b1, 1'b0, 1'b0, 11'd132},
    {1'b0, 1'b0, 1'b0, 11'h7F8},
    {1'b1, 1'b1, 1'b0, 11'h7F8},
    {1'b1, 1'b0, 1'b1, 11'h3FF},
    {1'b0, 1'b0, 1'b0, 11'h400}
  };

  function automatic logic [14:0] mk(input logic t, input logic [2:0] n, input logic [10:0] r);
    return {t, n, r};
  endfunction

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic push(input logic [1:0] v, input logic [14:0] p0, input logic [14:0] p1);
    @(negedge clk);
    in_vld = v; in_pkt0 = p0; in_pkt1 = p1;
    @(negedge clk);
    in_vld = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(4'd6, d);  chk("R3 reset status", d, 8'h00);
    rd(4'd10, d); chk("R11 reset events", d, 8'h00);
    chk("R11 reset irq_id", {irq, irq_id}, 3'b000);
    rd(4'd2, d);  chk("R8 default hp whole", d, 8'h1A);
    rd(4'd3, d);  chk("R8 default hp frac", d, 8'h00);

    // disabled bus
    push(2'b01, mk(1'b0, 3'd1, 11'h0A5), '0);
    rd(4'd6, d);  chk("R2 disabled bus ignored", d, 8'h00);

    // push both buses, order, select
    wr(4'd0, 8'h03);
    push(2'b11, mk(1'b0, 3'd1, 11'h0A5), mk(1'b1, 3'd6, 11'h3C2));
    push(2'b01, mk(1'b0, 3'd2, 11'h7F9), '0);
    rd(4'd6, d);  chk("R1 count bus0", d, 8'h02);
    rd(4'd7, d);  chk("R1 count bus1", d, 8'h01);
    rd(4'd8, d);  chk("R4 frac fields", d, 8'h0D);
    rd(4'd8, d);  chk("R4 frac reread", d, 8'h0D);
    rd(4'd6, d);  chk("R4 frac no pop", d, 8'h02);
    rd(4'd9, d);  chk("R5 whole value", d, 8'h14);
    rd(4'd6, d);  chk("R5 pop count", d, 8'h01);
    rd(4'd8, d);  chk("R1 second entry frac", d, 8'h11);
    rd(4'd9, d);  chk("R1 second entry whole", d, 8'hFF);
    wr(4'd0, 8'h07);
    rd(4'd8, d);  chk("R6 bus1 frac", d, 8'h72);
    rd(4'd9, d);  chk("R6 bus1 whole", d, 8'h78);
    rd(4'd7, d);  chk("R6 bus1 drained", d, 8'h00);
    rd(4'd9, d);  chk("R5 empty whole", d, 8'h00);
    rd(4'd7, d);  chk("R5 empty unchanged", d, 8'h00);
    wr(4'd10, 8'h07);

    // overflow
    wr(4'd0, 8'h01);
    for (int i = 1; i <= 9; i++) push(2'b01, mk(1'b0, 3'd0, 11'(i << 3)), '0);
    rd(4'd6, d);  chk("R3 full with overflow", d, 8'h88);
    rd(4'd6, d);  chk("R3 overflow cleared by read", d, 8'h08);
    for (int i = 1; i <= 8; i++) begin
      rd(4'd9, d); chk("R3 drain order, ninth dropped", d, 32'(i));
    end
    rd(4'd6, d);  chk("R3 empty after drain", d, 8'h00);

    // occupancy level event
    wr(4'd1, 8'h02);
    wr(4'd10, 8'h07);
    push(2'b01, mk(1'b1, 3'd0, 11'd5), '0);
    push(2'b01, mk(1'b1, 3'd0, 11'd6), '0);
    rd(4'd10, d); chk("R7 below level", d, 8'h00);
    push(2'b01, mk(1'b1, 3'd0, 11'd7), '0);
    chk("R12 wake pulse", wake, 3'b001);
    @(negedge clk);
    chk("R12 wake one cycle", wake, 3'b000);
    rd(4'd10, d); chk("R7 level reached", d, 8'h01);
    for (int i = 0; i < 3; i++) rd(4'd9, d);
    wr(4'd1, 8'h00);

    // voltage packets skip compare
    wr(4'd0, 8'h19);
    wr(4'd4, 8'h10);
    wr(4'd5, 8'h04);
    wr(4'd10, 8'h07);
    push(2'b01, mk(1'b1, 3'd0, 11'h3FF), '0);
    rd(4'd10, d); chk("R10 voltage no threshold event", d, 8'h01);
    rd(4'd8, d);  chk("R10 voltage no violation", d, 8'h47);
    rd(4'd9, d);

    // threshold vectors
    for (int v = 0; v < 10; v++) begin
      wr(4'd0, {2'b00, VEC[v][13], 5'b11001});
      wr(4'd10, 8'h07);
      push(2'b01, mk(1'b0, 3'd3, VEC[v][10:0]), '0);
      rd(4'd10, d); chk("R8/R9 threshold events", d, {5'b0, VEC[v][11], VEC[v][12], 1'b1});
      rd(4'd8, d);  chk("R9 violation flag", d[7], VEC[v][12] | VEC[v][11]);
      rd(4'd9, d);
    end

    // priority
    wr(4'd0, 8'h19);
    wr(4'd10, 8'h07);
    push(2'b01, mk(1'b0, 3'd0, 11'd208), '0);
    chk("R11 all pending", {irq, irq_id}, 3'b101);
    wr(4'd10, 8'h01);
    chk("R11 alert next", {irq, irq_id}, 3'b110);
    wr(4'd10, 8'h02);
    chk("R11 hp last", {irq, irq_id}, 3'b111);
    wr(4'd10, 8'h04);
    chk("R11 none pending", {irq, irq_id}, 3'b000);
    rd(4'd9, d);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule